// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a serial shift engine and a register interface. It holds two word FIFOs, sixteen entries each by default. Software fills the transmit FIFO and the shift engine drains it. The shift engine fills the receive FIFO and software drains it. Every push and pop is a one-cycle valid strobe, and the word at the head of each FIFO is always visible on its read port.

From the two fill counts the block derives six level flags. It also keeps two sticky event flags: receive overflow and transfer complete. The eight flags form a status byte. An enable byte with the same bit layout masks that status into a single interrupt line.

Both fill counts are visible on one packed output. A soft-reset strobe with a two-bit selector can empty either FIFO or both. The shift engine and the external bus protocol are outside this block.

Top module: `spi_fifo_stat`

## Requirements
- R1: Status bit 0 is 1 exactly when the TX count is 0. Bit 1 is 1 when the TX count is at least DEPTH/2 (8). Bit 2 is 1 when the TX count equals DEPTH (16). All three follow the count with no memory.
- R2: Status bit 3 is 1 when the RX count is nonzero. Bit 4 is 1 when the RX count is at least DEPTH/2. Bit 5 is 1 when the RX count equals DEPTH. All three follow the count with no memory.
- R3: Each FIFO returns words in the order they were pushed, and the head word is presented on its read port while the FIFO is non-empty. A push and a pop in the same cycle leave the count unchanged. A pop while the FIFO is empty is ignored.
- R4: A TX push while the TX FIFO holds DEPTH words is ignored, and the count stays at DEPTH.
- R5: An RX push while the RX FIFO holds DEPTH words drops the word and sets status bit 6. Bit 6 stays set until a clear strobe carries a 1 in mask bit 6. Clear-mask bits for level flags have no effect.
- R6: A one-cycle xfer_done pulse sets status bit 7. Bit 7 stays set until a clear strobe carries a 1 in mask bit 7. If a new set and a clear arrive in the same cycle, the set wins, and the same holds for bit 6.
- R7: An ien_wr strobe loads the enable byte, which uses the status bit positions. irq is 1 exactly when some status bit and its enable bit are both 1.
- R8: fill_counts[4:0] carries the TX count and fill_counts[9:5] carries the RX count.
- R9: A fifo_rst strobe empties the TX FIFO when selector bit 0 is 1 and the RX FIFO when selector bit 1 is 1. It overrides any push in the same cycle and leaves the sticky flags unchanged.
- R10: After reset, both counts are 0, status is 8'h01, the enable byte is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Software writes one TX word |
| tx_push_data | input | DATA_W | TX word to store |
| tx_pop | input | 1 | Shift engine takes the TX head word |
| tx_head | output | DATA_W | Current TX head word |
| rx_push | input | 1 | Shift engine delivers one RX word |
| rx_push_data | input | DATA_W | RX word to store |
| rx_pop | input | 1 | Software takes the RX head word |
| rx_head | output | DATA_W | Current RX head word |
| xfer_done | input | 1 | Transfer finished, sets status bit 7 |
| stat_clr | input | 1 | Write-one-to-clear strobe for sticky flags |
| stat_clr_mask | input | 8 | Bits to clear, in status layout |
| ien_wr | input | 1 | Enable-byte write strobe |
| ien_wr_data | input | 8 | New enable byte |
| fifo_rst | input | 1 | Soft FIFO reset strobe |
| fifo_rst_sel | input | 2 | Bit 0 selects TX, bit 1 selects RX |
| status | output | 8 | Eight status flags |
| ien | output | 8 | Current enable byte |
| irq | output | 1 | Masked interrupt line |
| fill_counts | output | 2*CNT_W | RX count over TX count |

## Verification
The transmit FIFO is driven through a fill past capacity followed by a full drain. This separates the 0, 8 and 16 thresholds of the level flags from one another and shows that the write made while full is ignored. Pushes and pops in the same cycle, including at full and at empty, check that the count and the order survive the corner where one side of the operation must be refused. On the receive side, an overflow is followed by a clear of the wrong bit and then of the right bit, which tells a sticky flag apart from a level flag. A clear in the same cycle as a new completion shows which of the two wins. Soft resets with each selector value, combined with pushes in the same cycle, show that each FIFO is emptied on its own and that the sticky flags are not touched.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   localparam int unsigned NFLAG = 8;
   localparam int unsigned FL_TX_EMPTY = 0;
   localparam int unsigned FL_TX_HALF  = 1;
   localparam int unsigned FL_TX_FULL  = 2;
   localparam int unsigned FL_RX_READY = 3;
   localparam int unsigned FL_RX_HALF  = 4;
   localparam int unsigned FL_RX_FULL  = 5;
   localparam int unsigned FL_RX_OVF   = 6;
   localparam int unsigned FL_DONE     = 7;
   typedef logic [NFLAG-1:0] flag_vec_t;
   localparam int unsigned RST_SEL_TX = 0;
   localparam int unsigned RST_SEL_RX = 1;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
   parameter  int unsigned DATA_W = 32,
   parameter  int unsigned DEPTH  = 16,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     count
);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("spi_fifo_buf: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("spi_fifo_buf: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign do_push = push && (count != CNT_FULL) && !clr;
   assign do_pop  = pop && (count != '0) && !clr;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   // R4: the count never passes capacity
   a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_FULL);
   // R4: a push alone while full leaves the count at capacity
   a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clr && count == CNT_FULL) |=> count == CNT_FULL);
   // R3: a pop alone while empty changes nothing
   a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !clr && count == '0) |=> count == '0);
   // R9: a clear always empties the FIFO
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
   import spi_fifo_pkg::*;
#(
   parameter  int unsigned DEPTH   = 16,
   parameter  bit          IRQ_REG = 1'b0,
   localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   tx_count,
   input  logic [CW-1:0]   rx_count,
   input  logic            ovf_evt,
   input  logic            done_evt,
   input  logic            clr_valid,
   input  flag_vec_t       clr_mask,
   input  logic            ien_valid,
   input  flag_vec_t       ien_data,
   output flag_vec_t       status,
   output flag_vec_t       ien,
   output logic            irq
);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

   flag_vec_t level, set_evt, clr_hit, sticky_q;

   always_comb begin
      level = '0;
      level[FL_TX_EMPTY] = (tx_count == '0);
      level[FL_TX_HALF]  = (tx_count >= CNT_HALF);
      level[FL_TX_FULL]  = (tx_count == CNT_FULL);
      level[FL_RX_READY] = (rx_count != '0);
      level[FL_RX_HALF]  = (rx_count >= CNT_HALF);
      level[FL_RX_FULL]  = (rx_count == CNT_FULL);
      set_evt = '0;
      set_evt[FL_RX_OVF] = ovf_evt;
      set_evt[FL_DONE]   = done_evt;
   end

   assign clr_hit = clr_valid ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
      end else begin
         for (int i = 0; i < int'(NFLAG); i++) begin
            if (set_evt[i])      sticky_q[i] <= 1'b1;
            else if (clr_hit[i]) sticky_q[i] <= 1'b0;
         end
      end
   end

   assign status = level | sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ien <= '0;
      else if (ien_valid) ien <= ien_data;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |(status & ien);
         end
      end else begin : g_irq_comb
         assign irq = |(status & ien);
      end
   endgenerate

   // R6: a completion event is visible on the next cycle
   a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> status[FL_DONE]);
   // R6: the completion flag holds until cleared
   a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (status[FL_DONE] && !(clr_valid && clr_mask[FL_DONE])) |=> status[FL_DONE]);
   // R5: an overflow event is recorded
   a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> status[FL_RX_OVF]);
   // R7: the enable byte takes the written value
   a_r7_ien_load: assert property (@(posedge clk) disable iff (!rst_n)
      ien_valid |=> ien == $past(ien_data));
   // R1: empty and half-full never coexist
   a_r1_tx_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[FL_TX_EMPTY] && status[FL_TX_HALF]));
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
   import spi_fifo_pkg::*;
#(
   parameter  int unsigned DATA_W  = 32,
   parameter  int unsigned DEPTH   = 16,
   parameter  bit          IRQ_REG = 1'b0,
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_push,
   input  logic [DATA_W-1:0]  tx_push_data,
   input  logic               tx_pop,
   output logic [DATA_W-1:0]  tx_head,
   input  logic               rx_push,
   input  logic [DATA_W-1:0]  rx_push_data,
   input  logic               rx_pop,
   output logic [DATA_W-1:0]  rx_head,
   input  logic               xfer_done,
   input  logic               stat_clr,
   input  logic [7:0]         stat_clr_mask,
   input  logic               ien_wr,
   input  logic [7:0]         ien_wr_data,
   input  logic               fifo_rst,
   input  logic [1:0]         fifo_rst_sel,
   output logic [7:0]         status,
   output logic [7:0]         ien,
   output logic               irq,
   output logic [2*CNT_W-1:0] fill_counts
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tx_clr, rx_clr, rx_ovf;

   assign tx_clr = fifo_rst && fifo_rst_sel[RST_SEL_TX];
   assign rx_clr = fifo_rst && fifo_rst_sel[RST_SEL_RX];
   assign rx_ovf = rx_push && (rx_cnt == CNT_FULL) && !rx_clr;

   spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push), .push_data(tx_push_data),
      .pop(tx_pop), .head(tx_head), .count(tx_cnt));

   spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(rx_push), .push_data(rx_push_data),
      .pop(rx_pop), .head(rx_head), .count(rx_cnt));

   spi_fifo_flags #(.DEPTH(DEPTH), .IRQ_REG(IRQ_REG)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .tx_count(tx_cnt), .rx_count(rx_cnt),
      .ovf_evt(rx_ovf), .done_evt(xfer_done),
      .clr_valid(stat_clr), .clr_mask(stat_clr_mask),
      .ien_valid(ien_wr), .ien_data(ien_wr_data),
      .status(status), .ien(ien), .irq(irq));

   assign fill_counts = {rx_cnt, tx_cnt};

   // R9: soft reset of one FIFO leaves the other's count alone
   a_r9_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rst && fifo_rst_sel == 2'b01 && !rx_push && !rx_pop) |=> $stable(rx_cnt));
endmodule

// File: tb/spi_fifo_stat_test.sv
`timescale 1ns/1ps
module spi_fifo_stat_test;
   localparam int DW = 32;
   localparam int DEPTH = 16;
   localparam int CW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic [DW-1:0] tx_push_data = '0, rx_push_data = '0;
   logic [DW-1:0] tx_head, rx_head;
   logic xfer_done = 0, stat_clr = 0, ien_wr = 0, fifo_rst = 0;
   logic [7:0] stat_clr_mask = '0, ien_wr_data = '0;
   logic [1:0] fifo_rst_sel = '0;
   logic [7:0] status, ien;
   logic irq;
   logic [2*CW-1:0] fill_counts;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];
   bit m_ovf = 0, m_tc = 0;
   logic [7:0] m_ien = '0;
   logic [DW-1:0] seed = 32'h5A00_0000;

   always #2.5 clk = ~clk;

   spi_fifo_stat uut (
      .clk(clk), .rst_n(rst_n),
      .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_head(tx_head),
      .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_head(rx_head),
      .xfer_done(xfer_done), .stat_clr(stat_clr), .stat_clr_mask(stat_clr_mask),
      .ien_wr(ien_wr), .ien_wr_data(ien_wr_data),
      .fifo_rst(fifo_rst), .fifo_rst_sel(fifo_rst_sel),
      .status(status), .ien(ien), .irq(irq), .fill_counts(fill_counts));

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] model_status();
      logic [7:0] s;
      int ts = txq.size();
      int rs = rxq.size();
      s[0] = (ts == 0);
      s[1] = (ts >= DEPTH/2);
      s[2] = (ts == DEPTH);
      s[3] = (rs != 0);
      s[4] = (rs >= DEPTH/2);
      s[5] = (rs == DEPTH);
      s[6] = m_ovf;
      s[7] = m_tc;
      return s;
   endfunction

   task automatic compare();
      logic [7:0] s = model_status();
      chk("R1", "tx empty flag", 32'(status[0]), 32'(s[0]));
      chk("R1", "tx half flag", 32'(status[1]), 32'(s[1]));
      chk("R1", "tx full flag", 32'(status[2]), 32'(s[2]));
      chk("R2", "rx ready flag", 32'(status[3]), 32'(s[3]));
      chk("R2", "rx half flag", 32'(status[4]), 32'(s[4]));
      chk("R2", "rx full flag", 32'(status[5]), 32'(s[5]));
      chk("R5", "overflow flag", 32'(status[6]), 32'(s[6]));
      chk("R6", "done flag", 32'(status[7]), 32'(s[7]));
      chk("R7", "enable byte", 32'(ien), 32'(m_ien));
      chk("R7", "irq", 32'(irq), 32'(|(s & m_ien)));
      chk("R8", "fill counts", 32'(fill_counts), 32'({CW'(rxq.size()), CW'(txq.size())}));
      if (txq.size() > 0) chk("R3", "tx head", tx_head, txq[0]);
      if (rxq.size() > 0) chk("R3", "rx head", rx_head, rxq[0]);
   endtask

   task automatic model_update();
      int ts = txq.size();
      int rs = rxq.size();
      bit tcl = fifo_rst && fifo_rst_sel[0];
      bit rcl = fifo_rst && fifo_rst_sel[1];
      if (tcl) txq.delete();
      else begin
         if (tx_pop && ts > 0) void'(txq.pop_front());
         if (tx_push && ts < DEPTH) txq.push_back(tx_push_data);
      end
      if (rcl) rxq.delete();
      else begin
         if (rx_pop && rs > 0) void'(rxq.pop_front());
         if (rx_push && rs < DEPTH) rxq.push_back(rx_push_data);
      end
      if (rx_push && rs == DEPTH && !rcl) m_ovf = 1;
      else if (stat_clr && stat_clr_mask[6]) m_ovf = 0;
      if (xfer_done) m_tc = 1;
      else if (stat_clr && stat_clr_mask[7]) m_tc = 0;
      if (ien_wr) m_ien = ien_wr_data;
   endtask

   task automatic idle();
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
      xfer_done = 0; stat_clr = 0; ien_wr = 0; fifo_rst = 0;
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      idle();
   endtask

   function automatic logic [DW-1:0] next_word();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      chk("R10", "status after reset", 32'(status), 32'h01);
      chk("R10", "enable after reset", 32'(ien), 32'h0);
      chk("R10", "irq after reset", 32'(irq), 32'h0);
      chk("R10", "fill after reset", 32'(fill_counts), 32'h0);
      compare();

      // R7 enable on rx ready only
      ien_wr = 1; ien_wr_data = 8'h08; step();
      chk("R7", "irq masked", 32'(irq), 32'h0);

      // R1 R4 fill TX beyond capacity
      for (int i = 0; i < DEPTH + 1; i++) begin
         tx_push = 1; tx_push_data = next_word(); step();
      end
      chk("R4", "tx count at cap", 32'(fill_counts[CW-1:0]), 32'd16);
      chk("R1", "tx full at cap", 32'(status[2]), 32'h1);
      // R4 push and pop while full: push refused, count drops by one
      tx_push = 1; tx_pop = 1; tx_push_data = next_word(); step();
      chk("R4", "tx count after full push+pop", 32'(fill_counts[CW-1:0]), 32'd15);
      // R3 simultaneous push and pop keep the count
      for (int i = 0; i < 4; i++) begin
         tx_push = 1; tx_pop = 1; tx_push_data = next_word(); step();
      end
      chk("R3", "tx count steady", 32'(fill_counts[CW-1:0]), 32'd15);
      // drain fully, then pop on empty
      for (int i = 0; i < DEPTH + 2; i++) begin
         tx_pop = 1; step();
      end
      chk("R3", "tx empty after drain", 32'(status[0]), 32'h1);
      // R3 push and pop on empty: pop ignored, push lands
      tx_push = 1; tx_pop = 1; tx_push_data = next_word(); step();
      chk("R3", "tx count after empty push+pop", 32'(fill_counts[CW-1:0]), 32'd1);

      // R2 R5 fill RX and overflow
      ien_wr = 1; ien_wr_data = 8'h40; step();
      for (int i = 0; i < DEPTH + 2; i++) begin
         rx_push = 1; rx_push_data = next_word(); step();
      end
      chk("R5", "overflow set", 32'(status[6]), 32'h1);
      chk("R7", "irq on overflow", 32'(irq), 32'h1);
      stat_clr = 1; stat_clr_mask = 8'hBF; step();
      chk("R5", "overflow kept by other mask bits", 32'(status[6]), 32'h1);
      chk("R5", "level flags unaffected by clear", 32'(status[5]), 32'h1);
      stat_clr = 1; stat_clr_mask = 8'h40; step();
      chk("R5", "overflow cleared", 32'(status[6]), 32'h0);
      for (int i = 0; i < 10; i++) begin
         rx_pop = 1; step();
      end
      chk("R2", "rx half gone", 32'(status[4]), 32'h0);

      // R6 transfer complete sticky
      ien_wr = 1; ien_wr_data = 8'h80; step();
      xfer_done = 1; step();
      repeat (3) step();
      chk("R6", "done held", 32'(status[7]), 32'h1);
      xfer_done = 1; stat_clr = 1; stat_clr_mask = 8'h80; step();
      chk("R6", "set wins over clear", 32'(status[7]), 32'h1);
      stat_clr = 1; stat_clr_mask = 8'h80; step();
      chk("R6", "done cleared", 32'(status[7]), 32'h0);
      chk("R7", "irq drops", 32'(irq), 32'h0);

      // R9 soft reset variants
      for (int i = 0; i < 5; i++) begin
         tx_push = 1; tx_push_data = next_word(); step();
      end
      xfer_done = 1; step();
      fifo_rst = 1; fifo_rst_sel = 2'b01; tx_push = 1; tx_push_data = next_word(); step();
      chk("R9", "tx emptied", 32'(fill_counts[CW-1:0]), 32'd0);
      chk("R9", "rx kept", 32'(fill_counts[2*CW-1:CW]), 32'd6);
      chk("R9", "sticky kept", 32'(status[7]), 32'h1);
      tx_push = 1; tx_push_data = next_word(); step();
      fifo_rst = 1; fifo_rst_sel = 2'b10; rx_push = 1; rx_push_data = next_word(); step();
      chk("R9", "rx emptied", 32'(fill_counts[2*CW-1:CW]), 32'd0);
      chk("R9", "tx kept", 32'(fill_counts[CW-1:0]), 32'd1);
      rx_push = 1; rx_push_data = next_word(); step();
      fifo_rst = 1; fifo_rst_sel = 2'b11; step();
      chk("R9", "both emptied", 32'(fill_counts), 32'd0);
      fifo_rst = 1; fifo_rst_sel = 2'b00; tx_push = 1; tx_push_data = next_word(); step();
      chk("R9", "no select no clear", 32'(fill_counts[CW-1:0]), 32'd1);
      repeat (2) step();

      finish_run();
   end
endmodule